// File: doc/BRIEF.md
# Serial Clock Synthesizer Programming Sequencer

This block loads a 24-bit configuration word into an external frequency synthesizer. The synthesizer listens on two bit-banged lines, a serial clock and a serial data line. A one-cycle start pulse captures the word. The block then walks through a fixed list of line states. It opens with an unlock preamble. It then sends every bit of the word as a four-state waveform, and the order of the four states depends on the bit value. A short stop pattern closes the list. Each state is held for a programmable number of system clock cycles.

When the list is finished, the two lines are left driving the word's 2-bit clock-select field. That value stays in place until the next operation. A blanking output covers the whole operation, so a display can be kept dark while its pixel clock is being changed. A busy output and a one-cycle done pulse tell the controlling logic where the operation stands.

Top module: `synth_prog_seq`

## Requirements
- R1: After reset the block is idle: `lines_o` is 00, and `blank_o`, `busy_o` and `done_o` are all low.
- R2: `lines_o` carries the data line in bit 1 and the clock line in bit 0, so none=00, clock=01, data=10 and both=11. The state list begins with the preamble 00, 10, then six repeats of the pair 11, 10, then 00, 01, 00, 01.
- R3: All 24 bits of the word follow the preamble, bit 0 first. A bit of value 1 is sent as 01, 00, 10, 11.
- R4: A bit of value 0 is sent as 11, 10, 00, 01.
- R5: After bit 23 comes the stop pattern 11, 10, 11.
- R6: After the stop pattern, `lines_o` takes the value of word bits 23:22. It keeps that value through idle, and a change of `cfg_word_i` while idle does not affect it, until the next accepted start.
- R7: Every state in the list is held for HOLD_CYCLES clock cycles (default 4). The first state appears in the cycle after the start is accepted.
- R8: `busy_o` is high from the cycle after an accepted start until the select value is applied. A start pulse while `busy_o` is high is ignored, together with its word.
- R9: `done_o` is a one-cycle pulse. It appears in the first cycle in which the select value is on the lines and `busy_o` is low.
- R10: `blank_o` is high in every cycle that shows a state of the list and in the done cycle. It falls in the cycle after the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| cfg_word_i | input | 24 | Configuration word; bits 23:22 are the clock select |
| lines_o | output | 2 | Serial lines: bit 1 data, bit 0 clock |
| blank_o | output | 1 | Screen blanking for the whole operation |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The start is sampled at a clock edge. State k of the 117-state list then occupies cycles k*HOLD_CYCLES+1 through (k+1)*HOLD_CYCLES after that edge. The done cycle, carrying the select value, follows at cycle 117*HOLD_CYCLES+1, and blanking is released one cycle later. The bench builds each word's expected state list arithmetically and samples the outputs on the falling edge of every one of those cycles, so that each hold cycle, the done cycle and the blank release are compared at their exact positions. Ignored starts are injected in the middle of an operation and checked by confirming that the running sequence and the final select value are unchanged.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;

  // Line state encoding: bit 1 = data line, bit 0 = clock line (R2)
  typedef enum logic [1:0] {
    LN_NONE = 2'b00,
    LN_CLK  = 2'b01,
    LN_DATA = 2'b10,
    LN_BOTH = 2'b11
  } line_t;

  // Number of states in the unlock preamble
  function automatic int unsigned preamble_len(int unsigned pairs);
    return 2 + 2 * pairs + 4;
  endfunction

  // Number of states in the whole list: preamble, bit waveforms and stop pattern
  function automatic int unsigned seq_len(int unsigned pairs, int unsigned bits);
    return preamble_len(pairs) + 4 * bits + 3;
  endfunction

  // Preamble state k: 00, 10, (11,10) x pairs, 00, 01, 00, 01
  function automatic line_t preamble_state(int unsigned k, int unsigned pairs);
    if (k == 0) return LN_NONE;
    if (k == 1) return LN_DATA;
    if (k < 2 + 2 * pairs) return (k % 2 == 0) ? LN_BOTH : LN_DATA;
    return (k % 2 == 0) ? LN_NONE : LN_CLK;
  endfunction

  // Four-phase waveform of one data bit (R3, R4)
  function automatic line_t bit_state(logic b, logic [1:0] ph);
    if (b) begin
      case (ph)
        2'd0:    return LN_CLK;
        2'd1:    return LN_NONE;
        2'd2:    return LN_DATA;
        default: return LN_BOTH;
      endcase
    end
    case (ph)
      2'd0:    return LN_BOTH;
      2'd1:    return LN_DATA;
      2'd2:    return LN_NONE;
      default: return LN_CLK;
    endcase
  endfunction

  // Stop pattern 11, 10, 11 (R5)
  function automatic line_t stop_state(int unsigned k);
    return (k == 1) ? LN_DATA : LN_BOTH;
  endfunction

endpackage

// File: rtl/synth_hold_timer.sv
module synth_hold_timer #(
  parameter int unsigned HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic adv_o
);
  localparam int unsigned CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (!run_i)        cnt <= '0;
    else if (cnt == LAST)   cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // One advance pulse per HOLD cycles of running (R7)
  assign adv_o = run_i && (cnt == LAST);
endmodule

// File: rtl/synth_seq_ctrl.sv
module synth_seq_ctrl #(
  parameter int unsigned TOTAL  = 117,
  parameter int unsigned STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              adv_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              accept_o,
  output logic              finish_o,
  output logic [STEP_W-1:0] step_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL - 1);

  logic at_last;

  // A start is taken only while idle (R8)
  assign accept_o = start_i && !busy_o;
  assign at_last  = (step_o == LAST_STEP);
  assign finish_o = busy_o && adv_i && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
      step_o <= '0;
    end else begin
      done_o <= finish_o;
      if (accept_o) begin
        busy_o <= 1'b1;
        step_o <= '0;
      end else if (busy_o && adv_i) begin
        if (at_last) busy_o <= 1'b0;
        else         step_o <= step_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/synth_line_enc.sv
module synth_line_enc
  import synth_prog_pkg::*;
#(
  parameter int unsigned WORD_W = 24,
  parameter int unsigned PAIRS  = 6,
  parameter int unsigned STEP_W = 7
) (
  input  logic [STEP_W-1:0] step_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [1:0]        line_o
);
  localparam int unsigned PRE_LEN = preamble_len(PAIRS);
  localparam int unsigned BIT_END = PRE_LEN + 4 * WORD_W;
  localparam int unsigned IDX_W   = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  int unsigned      s;
  int unsigned      rel;
  logic [IDX_W-1:0] bit_idx;

  always_comb begin
    s       = 32'(step_i);
    rel     = s - PRE_LEN;
    bit_idx = IDX_W'(rel >> 2);
    if (s < PRE_LEN)
      line_o = preamble_state(s, PAIRS);
    else if (s < BIT_END)
      line_o = bit_state(word_i[bit_idx], rel[1:0]);
    else
      line_o = stop_state(s - BIT_END);
  end
endmodule

// File: rtl/synth_prog_seq.sv
module synth_prog_seq
  import synth_prog_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 4,
  parameter int unsigned WORD_W      = 24,
  parameter int unsigned PAIRS       = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] cfg_word_i,
  output logic [1:0]        lines_o,
  output logic              blank_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned TOTAL  = seq_len(PAIRS, WORD_W);
  localparam int unsigned STEP_W = $clog2(TOTAL);

  // Internal events, named for the checker
  logic              hold_adv;
  logic              seq_accept;
  logic              seq_finish;
  logic [STEP_W-1:0] seq_step;
  logic [1:0]        enc_line;

  logic [WORD_W-1:0] word_q;
  logic [1:0]        sel_q;

  synth_hold_timer #(.HOLD(HOLD_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (busy_o),
    .adv_o (hold_adv)
  );

  synth_seq_ctrl #(.TOTAL(TOTAL), .STEP_W(STEP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .adv_i    (hold_adv),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .accept_o (seq_accept),
    .finish_o (seq_finish),
    .step_o   (seq_step)
  );

  synth_line_enc #(.WORD_W(WORD_W), .PAIRS(PAIRS), .STEP_W(STEP_W)) u_enc (
    .step_i (seq_step),
    .word_i (word_q),
    .line_o (enc_line)
  );

  // The word is captured only on an accepted start; the select is applied at the end (R6, R8)
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= '0;
      sel_q  <= 2'b00;
    end else begin
      if (seq_accept) word_q <= cfg_word_i;
      if (seq_finish) sel_q  <= word_q[WORD_W-1 -: 2];
    end
  end

  assign lines_o = busy_o ? enc_line : sel_q;
  // Blanking spans the list and the done cycle (R10)
  assign blank_o = busy_o | done_o;
endmodule

// File: rtl/synth_prog_seq_chk.sv
module synth_prog_seq_chk #(
  parameter int unsigned TOTAL  = 117,
  parameter int unsigned STEP_W = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        lines_o,
  input logic              blank_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              adv,
  input logic [STEP_W-1:0] step
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(TOTAL - 1);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R10
  blank_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o || done_o) |-> blank_o);

  // R10
  blank_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blank_o) |-> $past(done_o));

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !$past(busy_o)) |-> $stable(lines_o));

  // R7
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !adv) |=> $stable(step));

  // R7
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && adv && step != LAST_STEP) |=> (step == $past(step) + 1'b1));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && step != '0) |=> (step != '0));

  // R2
  pre_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> (lines_o == 2'b00 && blank_o));
endmodule

bind synth_prog_seq synth_prog_seq_chk #(.TOTAL(TOTAL), .STEP_W(STEP_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .lines_o (lines_o),
  .blank_o (blank_o),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .adv     (hold_adv),
  .step    (seq_step)
);

// File: tb/tb_synth_prog_seq.sv
`timescale 1ns/1ps
module tb_synth_prog_seq;
  localparam int HOLD  = 4;
  localparam int W     = 24;
  localparam int PAIRS = 6;
  localparam int PRE   = 2 + 2 * PAIRS + 4;
  localparam int NSTEP = PRE + 4 * W + 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  word = '0;
  logic [1:0]    lines;
  logic          blank, busy, done;

  int checks = 0;
  int errors = 0;
  int fill_n = 0;
  logic [1:0] exp_seq [0:NSTEP-1];

  always #2.5 clk = ~clk;

  synth_prog_seq #(.HOLD_CYCLES(HOLD), .WORD_W(W), .PAIRS(PAIRS)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cfg_word_i (word),
    .lines_o    (lines),
    .blank_o    (blank),
    .busy_o     (busy),
    .done_o     (done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(input logic [1:0] v);
    exp_seq[fill_n] = v;
    fill_n++;
  endtask

  // Expected list built straight from the requirements R2..R5
  task automatic build(input logic [W-1:0] w);
    fill_n = 0;
    push(2'b00); push(2'b10);
    for (int p = 0; p < PAIRS; p++) begin push(2'b11); push(2'b10); end
    push(2'b00); push(2'b01); push(2'b00); push(2'b01);
    for (int b = 0; b < W; b++) begin
      if (w[b]) begin push(2'b01); push(2'b00); push(2'b10); push(2'b11); end
      else      begin push(2'b11); push(2'b10); push(2'b00); push(2'b01); end
    end
    push(2'b11); push(2'b10); push(2'b11);
  endtask

  task automatic run_op(input logic [W-1:0] w, input int intr_at, input logic [W-1:0] intr_w);
    string tag;
    build(w);
    @(negedge clk);
    word  = w;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NSTEP; k++) begin
      for (int h = 0; h < HOLD; h++) begin
        if (k != 0 || h != 0) begin
          @(negedge clk);
          start = 1'b0;
        end
        if (h != 0)                tag = "R7 hold";
        else if (k < PRE)          tag = "R2 preamble";
        else if (k < PRE + 4 * W)  tag = w[(k - PRE) / 4] ? "R3 bit one" : "R4 bit zero";
        else                       tag = "R5 stop";
        chk(tag, 32'(lines), 32'(exp_seq[k]));
        chk("R8 busy during list", 32'(busy), 1);
        chk("R10 blank during list", 32'(blank), 1);
        chk("R9 no early done", 32'(done), 0);
        if (k * HOLD + h == intr_at) begin
          start = 1'b1;   // R8: must be ignored
          word  = intr_w;
        end
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk("R9 done pulse", 32'(done), 1);
    chk("R8 busy released", 32'(busy), 0);
    chk("R6 select applied", 32'(lines), 32'(w[W-1 -: 2]));
    chk("R10 blank in done cycle", 32'(blank), 1);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 0);
    chk("R10 blank released", 32'(blank), 0);
    chk("R6 select held", 32'(lines), 32'(w[W-1 -: 2]));
    word = ~w;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R6 select held idle", 32'(lines), 32'(w[W-1 -: 2]));
      chk("R8 idle not busy", 32'(busy), 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset lines", 32'(lines), 0);
    chk("R1 reset blank", 32'(blank), 0);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset done", 32'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle lines", 32'(lines), 0);
    chk("R1 idle busy", 32'(busy), 0);

    run_op(24'h000000, -1, 24'h0);
    run_op(24'hFFFFFF, 100, 24'h123456);
    run_op(24'h5A3C96, -1, 24'h0);
    run_op(24'h800001, 7, 24'h000000);
    run_op(24'h6C0F35, 300, 24'hC00000);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule